// File: doc/BRIEF.md
# Stereo Echo Filter with Feedback

The block runs one stereo echo step per output sample. On a start strobe it fetches one left/right frame from a circular delay region in a byte-wide external RAM, pushes that frame into an eight-deep history per channel and filters the history with eight signed 8-bit coefficients. It then writes the echo-send mix plus scaled filter feedback back into the same RAM frame, and forms the final stereo output from the main mix and the filtered echo.

A sample-rate sequencer issues start once per sample period, after voice mixing has settled the main and echo-send accumulators. The delay region, coefficients, gains and flags come straight from configuration registers held by the surrounding logic. A single-cycle done pulse marks the moment the new outputs are valid. The memory port has one cycle of read latency and never reads and writes in the same cycle.

Top module: `echo_fir_unit`

## Requirements
- R1: While rst_ni is low and after it rises, out_l_o, out_r_o and done_o are 0 and neither mem_rd_o nor mem_wr_o is high. The first frame after reset uses delay offset 0.
- R2: A frame's base address is page_i*256 plus the current offset, modulo 65536. Exactly four reads are issued on consecutive cycles at base+0, +1, +2, +3, each taken modulo 65536. The bytes are left low, left high, right low, right high, each word signed 16-bit little-endian. Read data is taken one cycle after mem_rd_o.
- R3: The offset advances by 4 per frame. When the advanced value reaches or passes the delay length, it becomes 0 instead.
- R4: The delay length in bytes is delay_i*2048. It is reloaded only at a frame whose offset is 0; changes to delay_i at other frames have no effect until then. With length 0 every frame uses offset 0.
- R5: Each channel keeps its last 8 input samples. The filter sum is the sum of coefficient k times history entry k. Coefficient k is the signed byte coef_i[8k+7:8k]; coefficient 7 weighs the newest sample and coefficient 0 the sample 7 frames older.
- R6: The write-back word per channel is (send >>> 7) + ((sum * signed fbk_i) >>> 14), saturated to signed 16 bits. It is written little-endian to the same four addresses in the same byte order, after the reads.
- R7: When flags_i bit 5 is 1, no write is issued and the delay region keeps its contents.
- R8: Each output is (main * master volume + sum * signed echo volume) >>> 14, saturated to signed 16 bits.
- R9: When flags_i bit 6 is 1, both outputs are 0. The history still advances.
- R10: When signed mvol_l_i times signed mvol_r_i is less than signed surr_thr_i, the left master volume is negated before use.
- R11: done_o is a one-cycle pulse that rises on the 19th rising edge after the edge that samples start_i. The outputs change only on that edge. start_i is ignored while a frame is in progress.
- R12: mem_rd_o and mem_wr_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin one frame (taken when idle) |
| main_l_i | input | ACC_W | Main mix accumulator, left, signed |
| main_r_i | input | ACC_W | Main mix accumulator, right, signed |
| send_l_i | input | ACC_W | Echo-send accumulator, left, signed |
| send_r_i | input | ACC_W | Echo-send accumulator, right, signed |
| page_i | input | ADDR_W-8 | Delay region start page |
| delay_i | input | DLY_W | Delay length in 2048-byte units |
| coef_i | input | TAPS*8 | Filter coefficients, coefficient k at bits 8k+7:8k |
| fbk_i | input | 8 | Signed feedback gain |
| mvol_l_i | input | 8 | Signed master volume, left |
| mvol_r_i | input | 8 | Signed master volume, right |
| evol_l_i | input | 8 | Signed echo volume, left |
| evol_r_i | input | 8 | Signed echo volume, right |
| surr_thr_i | input | 16 | Signed surround threshold |
| flags_i | input | 8 | Bit 5 blocks write-back, bit 6 mutes output |
| mem_addr_o | output | ADDR_W | RAM byte address |
| mem_rd_o | output | 1 | RAM read strobe |
| mem_wr_o | output | 1 | RAM write strobe |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, one cycle after the read |
| out_l_o | output | 16 | Output sample, left |
| out_r_o | output | 16 | Output sample, right |
| done_o | output | 1 | Frame finished, outputs valid |

## Verification
The reads occupy the four cycles after the start edge, the writes the 15th to 18th cycles, and the outputs and done_o change together on the 19th edge. The bench drives start_i on a falling edge and counts falling edges. It expects done_o at the 20th falling edge after driving start, then checks outputs and RAM contents there and confirms on the next falling edge that the pulse has dropped. Memory strobes and addresses are checked at every falling edge against the frame base computed from the bench's own offset model. A second start_i inside a frame is checked by confirming that no further reads or done pulse follow the frame.

// File: rtl/echo_pkg.sv
package echo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_LAT,
    ST_MAC,
    ST_FB,
    ST_WR,
    ST_OUT
  } echo_st_t;

  localparam int unsigned FRAME_BYTES = 4;
  localparam int unsigned WB_OFF_BIT  = 5;
  localparam int unsigned MUTE_BIT    = 6;
endpackage

// File: rtl/echo_ptr.sv
module echo_ptr #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DLY_W     = 4,
  parameter int unsigned LEN_SHIFT = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [ADDR_W-9:0] page_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic [ADDR_W-1:0] base_o
);
  localparam int unsigned LEN_W = DLY_W + LEN_SHIFT;
  localparam int unsigned OFS_W = LEN_W + 1;

  logic [OFS_W-1:0]  ofs_q, len_q, len_eff, ofs_inc;
  logic [ADDR_W-1:0] base_q;

  always_comb begin
    len_eff = (ofs_q == '0) ? OFS_W'({delay_i, {LEN_SHIFT{1'b0}}}) : len_q;
    ofs_inc = ofs_q + OFS_W'(echo_pkg::FRAME_BYTES);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ofs_q  <= '0;
      len_q  <= '0;
      base_q <= '0;
    end else if (adv_i) begin
      base_q <= {page_i, 8'h00} + ADDR_W'(ofs_q);
      len_q  <= len_eff;
      ofs_q  <= (ofs_inc >= len_eff) ? '0 : ofs_inc;
    end
  end

  assign base_o = base_q;

  // R3
  ofs_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ofs_q[1:0] == 2'b00);
  // R3
  ofs_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ofs_q == '0) || (ofs_q < len_q));
endmodule

// File: rtl/echo_seq.sv
module echo_seq #(
  parameter int unsigned TAPS  = 8,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             wr_en_i,
  output logic             mem_rd_o,
  output logic             mem_wr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o,
  output logic             cap_o,
  output logic             lat_o,
  output logic             mac_o,
  output logic             fb_o,
  output logic             out_o,
  output logic             done_o
);
  import echo_pkg::*;

  localparam logic [CNT_W-1:0] LAST_BYTE = CNT_W'(FRAME_BYTES - 1);
  localparam logic [CNT_W-1:0] LAST_TAP  = CNT_W'(TAPS - 1);

  echo_st_t         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      ST_IDLE: if (start_i) begin st_d = ST_RD; cnt_d = '0; end
      ST_RD: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_BYTE) st_d = ST_LAT;
      end
      ST_LAT: begin st_d = ST_MAC; cnt_d = '0; end
      ST_MAC: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_TAP) st_d = ST_FB;
      end
      ST_FB: begin st_d = ST_WR; cnt_d = '0; end
      ST_WR: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_BYTE) st_d = ST_OUT;
      end
      ST_OUT:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= (st_q == ST_OUT);
    end
  end

  assign cnt_o    = cnt_q;
  assign mem_rd_o = (st_q == ST_RD);
  assign mem_wr_o = (st_q == ST_WR) && wr_en_i;
  assign adv_o    = (st_q == ST_IDLE) && start_i;
  assign cap_o    = (st_q == ST_RD) && (cnt_q != '0);
  assign lat_o    = (st_q == ST_LAT);
  assign mac_o    = (st_q == ST_MAC);
  assign fb_o     = (st_q == ST_FB);
  assign out_o    = (st_q == ST_OUT);
  assign done_o   = done_q;

  // R12
  no_rdwr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));
  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R11
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> !(st_q == ST_RD && cnt_q == '0));
endmodule

// File: rtl/echo_tap_mac.sv
module echo_tap_mac #(
  parameter int unsigned TAPS   = 8,
  parameter int unsigned SMP_W  = 16,
  parameter int unsigned COEF_W = 8,
  parameter int unsigned SUM_W  = 27,
  parameter int unsigned TAP_W  = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     shift_i,
  input  logic [SMP_W-1:0]         smp_i,
  input  logic                     clr_i,
  input  logic                     mac_i,
  input  logic [TAP_W-1:0]         tap_i,
  input  logic [TAPS*COEF_W-1:0]   coef_i,
  output logic signed [SUM_W-1:0]  acc_o
);
  logic signed [SMP_W-1:0]  hist_q [TAPS];
  logic signed [COEF_W-1:0] c_sel;
  logic signed [SMP_W-1:0]  h_sel;
  logic signed [SUM_W-1:0]  prod, acc_q;

  always_comb begin
    c_sel = $signed(coef_i[tap_i*COEF_W +: COEF_W]);
    h_sel = hist_q[tap_i];
    prod  = SUM_W'(c_sel) * SUM_W'(h_sel);
  end

  // hist_q[TAPS-1] is the newest sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < TAPS; i++) hist_q[i] <= '0;
      acc_q <= '0;
    end else begin
      if (shift_i) begin
        for (int i = 0; i < TAPS - 1; i++) hist_q[i] <= hist_q[i+1];
        hist_q[TAPS-1] <= $signed(smp_i);
      end
      if (clr_i)      acc_q <= '0;
      else if (mac_i) acc_q <= acc_q + prod;
    end
  end

  assign acc_o = acc_q;

  // R5
  shift_mac_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !mac_i);
endmodule

// File: rtl/echo_fir_unit.sv
module echo_fir_unit #(
  parameter int unsigned ACC_W     = 24,
  parameter int unsigned TAPS      = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DLY_W     = 4,
  parameter int unsigned LEN_SHIFT = 11
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [ACC_W-1:0]      main_l_i,
  input  logic [ACC_W-1:0]      main_r_i,
  input  logic [ACC_W-1:0]      send_l_i,
  input  logic [ACC_W-1:0]      send_r_i,
  input  logic [ADDR_W-9:0]     page_i,
  input  logic [DLY_W-1:0]      delay_i,
  input  logic [TAPS*8-1:0]     coef_i,
  input  logic [7:0]            fbk_i,
  input  logic [7:0]            mvol_l_i,
  input  logic [7:0]            mvol_r_i,
  input  logic [7:0]            evol_l_i,
  input  logic [7:0]            evol_r_i,
  input  logic [15:0]           surr_thr_i,
  input  logic [7:0]            flags_i,
  output logic [ADDR_W-1:0]     mem_addr_o,
  output logic                  mem_rd_o,
  output logic                  mem_wr_o,
  output logic [7:0]            mem_wdata_o,
  input  logic [7:0]            mem_rdata_i,
  output logic [15:0]           out_l_o,
  output logic [15:0]           out_r_o,
  output logic                  done_o
);
  import echo_pkg::*;

  localparam int unsigned COEF_W = 8;
  localparam int unsigned SMP_W  = 16;
  localparam int unsigned TAP_W  = (TAPS > 1) ? $clog2(TAPS) : 1;
  localparam int unsigned CNT_W  = (TAP_W > 2) ? TAP_W : 2;
  localparam int unsigned SUM_W  = SMP_W + COEF_W + TAP_W;
  localparam int unsigned MIX_A  = ACC_W + COEF_W + 2;
  localparam int unsigned MIX_B  = SUM_W + COEF_W;
  localparam int unsigned WIDE   = ((MIX_A > MIX_B) ? MIX_A : MIX_B) + 2;
  localparam logic signed [WIDE-1:0] SMAX = WIDE'(2**(SMP_W-1) - 1);
  localparam logic signed [WIDE-1:0] SMIN = -SMAX - WIDE'(1);

  function automatic logic [SMP_W-1:0] sat(input logic signed [WIDE-1:0] v);
    if (v > SMAX)      return SMAX[SMP_W-1:0];
    else if (v < SMIN) return SMIN[SMP_W-1:0];
    else               return v[SMP_W-1:0];
  endfunction

  logic [CNT_W-1:0]  cnt;
  logic              adv, cap, lat, mac, fb_en, out_en;
  logic [ADDR_W-1:0] base;
  logic [7:0]        byte_q [3];
  logic [1:0]        cap_idx;

  echo_seq #(.TAPS(TAPS), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni, .start_i,
    .wr_en_i (!flags_i[WB_OFF_BIT]),
    .mem_rd_o, .mem_wr_o,
    .cnt_o (cnt), .adv_o (adv), .cap_o (cap), .lat_o (lat),
    .mac_o (mac), .fb_o (fb_en), .out_o (out_en), .done_o
  );

  echo_ptr #(.ADDR_W(ADDR_W), .DLY_W(DLY_W), .LEN_SHIFT(LEN_SHIFT)) u_ptr (
    .clk_i, .rst_ni, .adv_i (adv), .page_i, .delay_i, .base_o (base)
  );

  assign mem_addr_o = base + ADDR_W'(cnt);
  assign cap_idx    = cnt[1:0] - 2'd1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 3; i++) byte_q[i] <= '0;
    end else if (cap) begin
      byte_q[cap_idx] <= mem_rdata_i;
    end
  end

  // per-channel operands, index 0 = left, 1 = right
  logic [SMP_W-1:0]        smp_new [2];
  logic signed [SUM_W-1:0] acc     [2];
  logic signed [ACC_W-1:0] main_v  [2];
  logic signed [ACC_W-1:0] send_v  [2];
  logic signed [8:0]       mvol    [2];
  logic signed [7:0]       evol    [2];
  logic signed [15:0]      surr_prod;
  logic [SMP_W-1:0]        fb_q    [2];
  logic [SMP_W-1:0]        out_q   [2];

  always_comb begin
    smp_new[0] = {byte_q[1], byte_q[0]};
    smp_new[1] = {mem_rdata_i, byte_q[2]};
    main_v[0]  = $signed(main_l_i);
    main_v[1]  = $signed(main_r_i);
    send_v[0]  = $signed(send_l_i);
    send_v[1]  = $signed(send_r_i);
    evol[0]    = $signed(evol_l_i);
    evol[1]    = $signed(evol_r_i);
    surr_prod  = 16'($signed(mvol_l_i)) * 16'($signed(mvol_r_i));
    mvol[0]    = 9'($signed(mvol_l_i));
    mvol[1]    = 9'($signed(mvol_r_i));
    if (surr_prod < $signed(surr_thr_i)) mvol[0] = -mvol[0];
  end

  for (genvar c = 0; c < 2; c++) begin : gen_ch
    logic signed [WIDE-1:0] fb_sum, mix_sum;

    echo_tap_mac #(
      .TAPS(TAPS), .SMP_W(SMP_W), .COEF_W(COEF_W), .SUM_W(SUM_W), .TAP_W(TAP_W)
    ) u_mac (
      .clk_i, .rst_ni,
      .shift_i (lat),
      .smp_i   (smp_new[c]),
      .clr_i   (lat),
      .mac_i   (mac),
      .tap_i   (TAP_W'(cnt)),
      .coef_i,
      .acc_o   (acc[c])
    );

    always_comb begin
      fb_sum  = (WIDE'(send_v[c]) >>> 7)
              + ((WIDE'(acc[c]) * WIDE'($signed(fbk_i))) >>> 14);
      mix_sum = (WIDE'(main_v[c]) * WIDE'(mvol[c])
              +  WIDE'(acc[c]) * WIDE'(evol[c])) >>> 14;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fb_q[c]  <= '0;
        out_q[c] <= '0;
      end else begin
        if (fb_en)  fb_q[c]  <= sat(fb_sum);
        if (out_en) out_q[c] <= flags_i[MUTE_BIT] ? '0 : sat(mix_sum);
      end
    end
  end

  always_comb begin
    unique case (cnt[1:0])
      2'd0:    mem_wdata_o = fb_q[0][7:0];
      2'd1:    mem_wdata_o = fb_q[0][15:8];
      2'd2:    mem_wdata_o = fb_q[1][7:0];
      default: mem_wdata_o = fb_q[1][15:8];
    endcase
  end

  assign out_l_o = out_q[0];
  assign out_r_o = out_q[1];

  // R9
  mute_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(flags_i[MUTE_BIT])) |-> (out_l_o == '0 && out_r_o == '0));
  // R11
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(out_l_o) && $stable(out_r_o)));
endmodule

// File: tb/echo_fir_unit_test.sv
`timescale 1ns/1ps
module echo_fir_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start = 1'b0;
  logic [23:0] main_l, main_r, send_l, send_r;
  logic [7:0]  page;
  logic [3:0]  delay;
  logic [63:0] coef;
  logic [7:0]  fbk, mvl, mvr, evl, evr, flags;
  logic [15:0] thr;
  logic [15:0] mem_addr;
  logic        mem_rd, mem_wr, done;
  logic [7:0]  mem_wdata, mem_rdata = 8'h00;
  logic [15:0] out_l, out_r;

  echo_fir_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .main_l_i(main_l), .main_r_i(main_r), .send_l_i(send_l), .send_r_i(send_r),
    .page_i(page), .delay_i(delay), .coef_i(coef), .fbk_i(fbk),
    .mvol_l_i(mvl), .mvol_r_i(mvr), .evol_l_i(evl), .evol_r_i(evr),
    .surr_thr_i(thr), .flags_i(flags),
    .mem_addr_o(mem_addr), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .out_l_o(out_l), .out_r_o(out_r), .done_o(done)
  );

  // behavioural RAM, low 12 address bits select the byte
  logic [7:0] ram [4096];
  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= ram[mem_addr[11:0]];
    if (mem_wr) ram[mem_addr[11:0]] <= mem_wdata;
  end

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint s8(input logic [7:0] v);   return longint'($signed(v)); endfunction
  function automatic longint s16(input logic [15:0] v); return longint'($signed(v)); endfunction
  function automatic longint s24(input logic [23:0] v); return longint'($signed(v)); endfunction
  function automatic longint sat(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  // reference model state
  longint m_off = 0, m_len = 0;
  longint hl [8], hr [8];
  longint exp_base = 0;
  int     rd_idx = 0, wr_idx = 0;
  bit     mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (mem_rd && mem_wr) chk(1'b0, "R12", 1, 0);
      if (mem_rd) begin
        chk(mem_addr == 16'((exp_base + rd_idx) % 65536), "R2 read addr",
            mem_addr, (exp_base + rd_idx) % 65536);
        rd_idx++;
      end
      if (mem_wr) begin
        chk(mem_addr == 16'((exp_base + wr_idx) % 65536), "R6 write addr",
            mem_addr, (exp_base + wr_idx) % 65536);
        wr_idx++;
      end
    end
  end

  task automatic frame(input bit extra_start);
    longint base, nxt, nl, nr, sl, sr, fl, fr, ml, mr, ol, or_, mvl_e;
    logic [7:0] pre [4];
    int lat;
    base = (longint'(page) * 256 + m_off) % 65536;
    if (m_off == 0) m_len = longint'(delay) * 2048;
    nxt = m_off + 4;
    m_off = (nxt >= m_len) ? 0 : nxt;
    for (int b = 0; b < 4; b++) pre[b] = ram[12'((base + b) % 65536)];
    nl = s16({pre[1], pre[0]});
    nr = s16({pre[3], pre[2]});
    for (int i = 0; i < 7; i++) begin hl[i] = hl[i+1]; hr[i] = hr[i+1]; end
    hl[7] = nl; hr[7] = nr;
    sl = 0; sr = 0;
    for (int i = 0; i < 8; i++) begin
      sl += s8(coef[8*i +: 8]) * hl[i];
      sr += s8(coef[8*i +: 8]) * hr[i];
    end
    fl = sat((s24(send_l) >>> 7) + ((sl * s8(fbk)) >>> 14));
    fr = sat((s24(send_r) >>> 7) + ((sr * s8(fbk)) >>> 14));
    mvl_e = s8(mvl);
    if (s8(mvl) * s8(mvr) < s16(thr)) mvl_e = -mvl_e;
    ml = sat((s24(main_l) * mvl_e + sl * s8(evl)) >>> 14);
    mr = sat((s24(main_r) * s8(mvr) + sr * s8(evr)) >>> 14);
    ol = flags[6] ? 0 : ml;
    or_ = flags[6] ? 0 : mr;

    exp_base = base; rd_idx = 0; wr_idx = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      if (extra_start && lat == 5) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    // start sampled one edge after driving; done arrives 19 edges later
    chk(lat == 20, "R11 latency", lat, 20);
    chk(rd_idx == 4, "R2 read count", rd_idx, 4);
    chk(wr_idx == (flags[5] ? 0 : 4), "R7 write count", wr_idx, flags[5] ? 0 : 4);
    chk(s16(out_l) == ol, flags[6] ? "R9 mute L" : "R8 out L", s16(out_l), ol);
    chk(s16(out_r) == or_, flags[6] ? "R9 mute R" : "R8 out R", s16(out_r), or_);
    if (flags[5]) begin
      for (int b = 0; b < 4; b++)
        chk(ram[12'((base + b) % 65536)] == pre[b], "R7 region kept",
            ram[12'((base + b) % 65536)], pre[b]);
    end else begin
      chk(s16({ram[12'((base + 1) % 65536)], ram[12'(base % 65536)]}) == fl, "R6 feedback L",
          s16({ram[12'((base + 1) % 65536)], ram[12'(base % 65536)]}), fl);
      chk(s16({ram[12'((base + 3) % 65536)], ram[12'((base + 2) % 65536)]}) == fr, "R6 feedback R",
          s16({ram[12'((base + 3) % 65536)], ram[12'((base + 2) % 65536)]}), fr);
    end
    @(negedge clk);
    chk(done == 1'b0, "R11 pulse", done, 0);
    if (extra_start) begin
      for (int k = 0; k < 3; k++) begin
        chk(!mem_rd && !done, "R11 busy start ignored", mem_rd, 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic rand_inputs();
    main_l = 24'($urandom); main_r = 24'($urandom);
    send_l = 24'($urandom); send_r = 24'($urandom);
    coef = {$urandom, $urandom};
    fbk = 8'($urandom); mvl = 8'($urandom); mvr = 8'($urandom);
    evl = 8'($urandom); evr = 8'($urandom);
    thr = 16'($urandom_range(0, 3) == 0 ? $urandom : 16'h8000);
    flags = {1'b0, ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0), 5'b0};
  endtask

  initial begin
    #3000000;
    bad++; total++;
    $display("FAIL watchdog act=1 exp=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 4096; i++) ram[i] = 8'($urandom);
    for (int i = 0; i < 8; i++) begin hl[i] = 0; hr[i] = 0; end
    main_l = '0; main_r = '0; send_l = '0; send_r = '0;
    page = 8'h20; delay = 4'd1; coef = '0; fbk = '0;
    mvl = 8'd64; mvr = 8'd64; evl = 8'd64; evr = 8'd64;
    thr = 16'h8000; flags = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(out_l == 0 && out_r == 0, "R1 outputs", out_l, 0);
    chk(!done && !mem_rd && !mem_wr, "R1 strobes", {done, mem_rd, mem_wr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_l == 0 && !done, "R1 after release", out_l, 0);
    mon_on = 1'b1;

    // R5 newest sample weighs coefficient 7
    coef = 64'h40_00_00_00_00_00_00_00;
    repeat (3) frame(1'b0);
    // R5 oldest sample weighs coefficient 0
    coef = 64'h00_00_00_00_00_00_00_40;
    repeat (9) frame(1'b0);

    // R8 saturation both ways
    coef = '0; main_l = 24'h7FFFFF; main_r = 24'h800000; mvl = 8'd127; mvr = 8'd127;
    frame(1'b0);
    // R6 feedback saturation
    send_l = 24'h7FFFFF; send_r = 24'h800000;
    frame(1'b0);

    // R10 surround: 40 * -50 < 0 negates left
    main_l = 24'd100000; main_r = 24'd100000; mvl = 8'd40; mvr = 8'hCE; thr = 16'd0;
    frame(1'b0);
    thr = 16'h8000;
    frame(1'b0);

    // R9 mute, R7 write-back off
    flags = 8'h40; frame(1'b0);
    flags = 8'h20; frame(1'b0);
    flags = 8'h60; frame(1'b0);
    flags = 8'h00;

    // R11 start during a frame is ignored
    frame(1'b1);

    // random frames
    for (int n = 0; n < 250; n++) begin
      rand_inputs();
      frame(1'b0);
    end

    // R2 address wrap past 65535, R3 offset wrap, R4 late delay change
    flags = 8'h00; page = 8'hFF; delay = 4'd1;
    for (int n = 0; n < 100; n++) begin rand_inputs(); flags = 8'h00; frame(1'b0); end
    delay = 4'd0;
    for (int n = 0; n < 430; n++) begin rand_inputs(); flags = 8'h00; frame(1'b0); end
    // R4 zero length: offset stays at 0
    chk(m_off == 0, "R4 model at zero", m_off, 0);
    repeat (4) frame(1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule